// File: doc/BRIEF.md
# Quarter-Wave Sine/Cosine Generator with Interpolation

This block turns a phase word into a pair of signed amplitude samples: the sine of the phase and the cosine of the same phase. The samples go to a digital-to-analog converter path. Only the first quadrant of the sine is held in a table, and that table is computed at elaboration. The full cycle is rebuilt by folding. The two top phase bits pick the quadrant. The position inside the quadrant is mirrored in the second and fourth quadrants, and the result is negated in the lower half of the cycle.

The low phase bits below the table address act as an interpolation fraction between two neighbouring table entries. The cosine lane is the sine lane run on the phase advanced by a quarter turn. A valid flag travels with the data through a fixed three-stage pipeline: fold, table read, then interpolate and register. The output registers hold their last sample while no new sample arrives.

Top module: `sincos_lut`

## Requirements
- R1: A phase word sampled on a rising edge with `phase_vld_i` high produces its samples, with `smp_vld_o` high, exactly three rising edges later, counting the sampling edge as the first. `smp_vld_o` is low in every other cycle.
- R2: Let q be the top two phase bits and p the lower PHASE_W-2 bits. When q[0]=1 the folded position is 2^(PHASE_W-2)-p, otherwise it is p. When q[1]=1 the magnitude is negated to give a two's-complement result. As a consequence, a sample whose phase MSB is set is never positive, and one whose MSB is clear is never negative.
- R3: No output ever takes the value -2^(AMP_W-1). Magnitudes are clamped to A = 2^(AMP_W-1)-1.
- R4: `cos_o` equals the sine result for the phase (phase_i + 2^(PHASE_W-2)) mod 2^PHASE_W.
- R5: Table entry T[k] = round-half-up(A·sin(π·k / 2^(ADDR_W+1))) for k = 0 … 2^ADDR_W, with ADDR_W = PHASE_W-2-FRAC_W. The folded position divided by 2^FRAC_W gives k. When the fraction is zero, the magnitude is T[k].
- R6: With fraction f (the low FRAC_W bits of the folded position), the magnitude is T[k] + floor(((T[k+1]-T[k])·f + 2^(FRAC_W-1)) / 2^FRAC_W). Here k+1 is held at 2^ADDR_W when k is already at the top entry.
- R7: While `smp_vld_o` is low, `sin_o` and `cos_o` keep the values of the last valid sample.
- R8: While `rst_ni` is low, `smp_vld_o`, `sin_o` and `cos_o` are zero whatever the inputs do.
- R9: Phase 0 gives (sin, cos) = (0, +A). A quarter turn gives (+A, 0). A half turn gives (0, -A). Three quarters gives (-A, 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_vld_i | input | 1 | Phase word is valid this cycle |
| phase_i | input | PHASE_W | Phase word, full scale is one cycle |
| smp_vld_o | output | 1 | Output samples are new this cycle |
| sin_o | output | AMP_W | Signed sine sample |
| cos_o | output | AMP_W | Signed cosine sample |

## Verification
The two lanes fold differently in the same cycle. A phase whose position is zero in an odd quadrant sends one lane to the mirrored top table entry, with its neighbour index clamped, while the other lane reads entry zero of an even quadrant. At the same time a finished sample leaves the output register as a new phase enters the fold stage. Cardinal phases, quadrant-edge phases and positions one step on either side of the edges are therefore driven back to back, without idle cycles. The scoreboard compares both lanes exactly against a model built from the table formula, and checks that each sample arrives on its due cycle.

// File: rtl/sincos_pkg.sv
`timescale 1ns/1ps
package sincos_pkg;

  // Rounded first-quadrant sine sample k of 2^addr_w, scaled to the signed full scale
  function automatic int quarter_sine(input int k, input int addr_w, input int amp_w);
    real x;
    real term;
    real sum;
    real amp;
    x    = 1.5707963267948966 * real'(k) / real'(1 << addr_w);
    term = x;
    sum  = x;
    for (int i = 1; i < 12; i++) begin
      term = -term * x * x / real'((2 * i) * (2 * i + 1));
      sum  = sum + term;
    end
    amp = real'((1 << (amp_w - 1)) - 1);
    return $rtoi(sum * amp + 0.5);
  endfunction

endpackage

// File: rtl/sincos_fold.sv
`timescale 1ns/1ps
module sincos_fold #(
  parameter int PHASE_W = 14,
  parameter int FRAC_W  = 4,
  localparam int POS_W  = PHASE_W - 2,
  localparam int ADDR_W = POS_W - FRAC_W
) (
  input  logic [PHASE_W-1:0] phase_i,
  output logic [ADDR_W:0]    idx_o,
  output logic [FRAC_W-1:0]  frac_o,
  output logic               neg_o
);

  localparam logic [POS_W:0] SPAN = (POS_W + 1)'(1) << POS_W;

  logic [POS_W:0] pos;
  logic [POS_W:0] mir;

  always_comb begin
    pos = {1'b0, phase_i[POS_W-1:0]};
    // odd quadrants run backwards; zero position lands on the top entry
    mir = phase_i[POS_W] ? SPAN - pos : pos;
  end

  assign idx_o  = mir[POS_W:FRAC_W];
  assign frac_o = mir[FRAC_W-1:0];
  assign neg_o  = phase_i[PHASE_W-1];

endmodule

// File: rtl/sincos_qrom.sv
`timescale 1ns/1ps
module sincos_qrom import sincos_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12,
  localparam int MAG_W = AMP_W - 1,
  localparam int DEPTH = (1 << ADDR_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ADDR_W:0]  idx_i,
  output logic [MAG_W-1:0] lo_o,
  output logic [MAG_W-1:0] hi_o
);

  localparam logic [ADDR_W:0] TOP = (ADDR_W + 1)'(DEPTH - 1);

  logic [MAG_W-1:0] tab [DEPTH];
  logic [ADDR_W:0]  idx_nxt;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    localparam int V = quarter_sine(k, ADDR_W, AMP_W);
    assign tab[k] = MAG_W'(V);
  end

  assign idx_nxt = (idx_i == TOP) ? idx_i : idx_i + (ADDR_W + 1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= '0;
      hi_o <= '0;
    end else if (en_i) begin
      lo_o <= tab[idx_i];
      hi_o <= tab[idx_nxt];
    end
  end

endmodule

// File: rtl/sincos_interp.sv
`timescale 1ns/1ps
module sincos_interp #(
  parameter int AMP_W   = 12,
  parameter int FRAC_W  = 4,
  localparam int MAG_W  = AMP_W - 1
) (
  input  logic [MAG_W-1:0]        lo_i,
  input  logic [MAG_W-1:0]        hi_i,
  input  logic [FRAC_W-1:0]       frac_i,
  input  logic                    neg_i,
  output logic signed [AMP_W-1:0] smp_o
);

  localparam int PROD_W = MAG_W + FRAC_W + 1;
  localparam logic [MAG_W:0] MAG_MAX = (MAG_W + 1)'((1 << MAG_W) - 1);

  logic [MAG_W-1:0]  diff;
  logic [PROD_W-1:0] prod;
  logic [MAG_W:0]    mag;
  logic [MAG_W:0]    mag_sat;

  always_comb begin
    diff    = (hi_i >= lo_i) ? hi_i - lo_i : '0;
    prod    = PROD_W'(diff) * PROD_W'(frac_i) + PROD_W'(1 << (FRAC_W - 1));
    mag     = {1'b0, lo_i} + (MAG_W + 1)'(prod >> FRAC_W);
    mag_sat = (mag > MAG_MAX) ? MAG_MAX : mag;
    smp_o   = neg_i ? -$signed(mag_sat) : $signed(mag_sat);
  end

endmodule

// File: rtl/sincos_lut.sv
`timescale 1ns/1ps
module sincos_lut #(
  parameter int PHASE_W = 14,
  parameter int FRAC_W  = 4,
  parameter int AMP_W   = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    phase_vld_i,
  input  logic [PHASE_W-1:0]      phase_i,
  output logic                    smp_vld_o,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o
);

  localparam int LANES  = 2;
  localparam int POS_W  = PHASE_W - 2;
  localparam int ADDR_W = POS_W - FRAC_W;
  localparam int MAG_W  = AMP_W - 1;

  logic v1_q;
  logic v2_q;
  logic signed [AMP_W-1:0] smp [LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= phase_vld_i;
      v2_q <= v1_q;
    end
  end

  // lane 0 is sine, lane 1 is the same fold a quarter turn ahead
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [PHASE_W-1:0] OFS = PHASE_W'(l) << POS_W;

    logic [PHASE_W-1:0] ph;
    logic [ADDR_W:0]    idx_d;
    logic [FRAC_W-1:0]  frac_d;
    logic               neg_d;
    logic [ADDR_W:0]    idx_q;
    logic [FRAC_W-1:0]  frac_q;
    logic               neg_q;
    logic [FRAC_W-1:0]  frac_q2;
    logic               neg_q2;
    logic [MAG_W-1:0]   lo;
    logic [MAG_W-1:0]   hi;

    assign ph = phase_i + OFS;

    sincos_fold #(.PHASE_W(PHASE_W), .FRAC_W(FRAC_W)) u_fold (
      .phase_i (ph),
      .idx_o   (idx_d),
      .frac_o  (frac_d),
      .neg_o   (neg_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        idx_q  <= '0;
        frac_q <= '0;
        neg_q  <= 1'b0;
      end else if (phase_vld_i) begin
        idx_q  <= idx_d;
        frac_q <= frac_d;
        neg_q  <= neg_d;
      end
    end

    sincos_qrom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (v1_q),
      .idx_i  (idx_q),
      .lo_o   (lo),
      .hi_o   (hi)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        frac_q2 <= '0;
        neg_q2  <= 1'b0;
      end else if (v1_q) begin
        frac_q2 <= frac_q;
        neg_q2  <= neg_q;
      end
    end

    sincos_interp #(.AMP_W(AMP_W), .FRAC_W(FRAC_W)) u_interp (
      .lo_i   (lo),
      .hi_i   (hi),
      .frac_i (frac_q2),
      .neg_i  (neg_q2),
      .smp_o  (smp[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_vld_o <= 1'b0;
      sin_o     <= '0;
      cos_o     <= '0;
    end else begin
      smp_vld_o <= v2_q;
      if (v2_q) begin
        sin_o <= smp[0];
        cos_o <= smp[1];
      end
    end
  end

endmodule

// File: rtl/sincos_lut_chk.sv
`timescale 1ns/1ps
module sincos_lut_chk #(
  parameter int AMP_W = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    phase_vld_i,
  input logic                    phase_msb_i,
  input logic                    smp_vld_o,
  input logic signed [AMP_W-1:0] sin_o,
  input logic signed [AMP_W-1:0] cos_o
);

  localparam logic signed [AMP_W-1:0] NEG_FULL = {1'b1, {(AMP_W - 1){1'b0}}};

  // edges seen since reset, saturating; gates every 3-deep look back
  logic [1:0] cyc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3) |-> (smp_vld_o == $past(phase_vld_i, 3)));

  a_r2_sign_lower_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3 && $past(phase_vld_i, 3) && $past(phase_msb_i, 3))
      |-> (sin_o[AMP_W-1] || sin_o == '0));

  a_r2_sign_upper_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3 && $past(phase_vld_i, 3) && !$past(phase_msb_i, 3))
      |-> !sin_o[AMP_W-1]);

  a_r3_no_full_negative: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_o |-> (sin_o != NEG_FULL && cos_o != NEG_FULL));

  a_r7_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_o |-> ($stable(sin_o) && $stable(cos_o)));

endmodule

bind sincos_lut sincos_lut_chk #(.AMP_W(AMP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_vld_i (phase_vld_i),
  .phase_msb_i (phase_i[PHASE_W-1]),
  .smp_vld_o   (smp_vld_o),
  .sin_o       (sin_o),
  .cos_o       (cos_o)
);

// File: tb/sincos_lut_bench.sv
`timescale 1ns/1ps
module sincos_lut_bench;

  localparam int PHASE_W = 14;
  localparam int FRAC_W  = 4;
  localparam int AMP_W   = 12;
  localparam int N       = 256;
  localparam int A       = 2047;
  localparam logic [13:0] QTR = 14'd4096;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              vld;
  logic [13:0]       phase;
  logic              smp_vld_o;
  logic signed [11:0] sin_o;
  logic signed [11:0] cos_o;

  sincos_lut #(.PHASE_W(PHASE_W), .FRAC_W(FRAC_W), .AMP_W(AMP_W)) u_sincos_lut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .phase_vld_i (vld),
    .phase_i     (phase),
    .smp_vld_o   (smp_vld_o),
    .sin_o       (sin_o),
    .cos_o       (cos_o)
  );

  typedef struct {
    int    es;
    int    ec;
    int    due;
    string tag;
  } item_t;

  item_t sb[$];
  item_t got;
  int    tab [0:N];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  int    last_es = 0;
  int    last_ec = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic build_table();
    for (int k = 0; k <= N; k++)
      tab[k] = $rtoi(real'(A) * $sin(3.141592653589793 * real'(k) / real'(2 * N)) + 0.5);
  endtask

  function automatic int model(input logic [13:0] ph);
    int p, pos, idx, fr, nx, mag;
    p   = int'(ph[11:0]);
    pos = ph[12] ? 4096 - p : p;
    idx = pos / 16;
    fr  = pos % 16;
    nx  = (idx == N) ? N : idx + 1;
    mag = tab[idx] + ((tab[nx] - tab[idx]) * fr + 8) / 16;
    if (mag > A) mag = A;
    return ph[13] ? -mag : mag;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic drive(input logic [13:0] ph, input string tag);
    item_t it;
    @(negedge clk);
    vld   = 1'b1;
    phase = ph;
    it.es  = model(ph);
    it.ec  = model(ph + QTR);
    it.due = cyc + 3;
    it.tag = tag;
    last_es = it.es;
    last_ec = it.ec;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (smp_vld_o) begin
        if (sb.size() == 0) begin
          check("R1 unexpected valid", 1, 0);
        end else begin
          got = sb.pop_front();
          check("R1 latency", cyc, got.due);
          check(got.tag, int'(sin_o), got.es);
          check("R4 cosine", int'(cos_o), got.ec);
          check("R3 no full negative", int'(sin_o == -12'sd2048 || cos_o == -12'sd2048), 0);
        end
      end else if (sb.size() > 0 && sb[0].due <= cyc) begin
        check("R1 missing valid", 0, 1);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    logic [15:0] s;
    build_table();
    rst_n = 1'b0;
    vld   = 1'b1;
    phase = 14'h1234;
    repeat (4) @(negedge clk);
    check("R8 valid in reset", int'(smp_vld_o), 0);
    check("R8 sin in reset", int'(sin_o), 0);
    check("R8 cos in reset", int'(cos_o), 0);
    vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R9 cardinal points (expected values follow from R5 as well)
    drive(14'd0,     "R9 phase 0");
    drive(14'd4096,  "R9 quarter");
    drive(14'd8192,  "R9 half");
    drive(14'd12288, "R9 three quarters");
    check("R9 table top", tab[N], A);
    check("R9 table zero", tab[0], 0);

    // R5 exact table points in every quadrant
    for (int q = 0; q < 4; q++) begin
      drive(14'((q << 12) | (0 << 4)),   "R5 entry 0");
      drive(14'((q << 12) | (1 << 4)),   "R5 entry 1");
      drive(14'((q << 12) | (17 << 4)),  "R5 entry 17");
      drive(14'((q << 12) | (128 << 4)), "R5 entry 128");
      drive(14'((q << 12) | (255 << 4)), "R5 entry 255");
    end

    // R2 quadrant edges and mirror endpoint, back to back
    drive(14'd4095,  "R2 before mirror edge");
    drive(14'd4097,  "R2 after mirror edge");
    drive(14'd8191,  "R2 before half");
    drive(14'd8193,  "R2 after half");
    drive(14'd12287, "R2 before 3q");
    drive(14'd12289, "R2 after 3q");
    drive(14'd16383, "R2 last phase");
    for (int i = 0; i < 6; i++) begin
      drive(14'(37 + i * 611),        "R2 upper half");
      drive(14'(37 + i * 611 + 8192), "R2 lower half");
    end

    // R3 around the peaks
    for (int i = 4080; i <= 4112; i++) drive(14'(i), "R3 near positive peak");
    for (int i = 12280; i <= 12296; i++) drive(14'(i), "R3 near negative peak");

    idle(6);
    check("R7 sin hold", int'(sin_o), last_es);
    check("R7 cos hold", int'(cos_o), last_ec);

    // R6 pseudo-random interpolation sweep with gaps
    s = 16'hACE1;
    for (int i = 0; i < 240; i++) begin
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
      drive(s[13:0], "R6 interpolation");
      if (i % 9 == 8) idle(1 + (i % 3));
    end

    idle(6);
    check("R7 sin hold end", int'(sin_o), last_es);
    check("R7 cos hold end", int'(cos_o), last_ec);
    check("R1 drained", sb.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule